// File: doc/BRIEF.md
# Watchdog Down-Counter with Masked Interrupt

This block is a 32-bit programmable down-counter reached through a small 16-bit register port. The count is held as two 16-bit halves that software writes and reads separately. A single-cycle tick-enable input, nominally asserted at a 5 MHz rate so that one decrement takes 200 ns, advances the counter while it is running. Two bits of a command register start and stop it. When the counter passes zero it wraps to all ones, keeps counting and raises a timer-complete status bit.

Status is collected in a 16-bit write-1-to-clear register. Other sources on the chip set status bits through per-bit set pulses. A 16-bit mask register selects which status bits drive the interrupt output. Reads are combinational, so software always sees the live count with no snapshot.

Top module: `wdt_timer_top`

Register addresses: 0 command, 1 count low half, 2 count high half, 3 mask, 4 status. Addresses 5 to 7 read as zero and ignore writes.

## Requirements
- R1: After synchronous reset the timer is stopped, the command register reads 0x0010, both count halves, the mask and the status read 0, and irq is low.
- R2: A command write with bit 5 set starts the timer. Afterwards the command register reads 0x0020, and each cycle with tick_en high lowers the 32-bit count by one.
- R3: A command write with bit 4 set and bit 5 clear stops the timer. The command register then reads 0x0010, the count freezes and stays readable, and tick_en has no effect. If bits 4 and 5 are written together, the timer runs.
- R4: The count is {high half at address 2, low half at address 1}. Writing one half loads that half and leaves the other unchanged. This holds whether the timer is running or stopped. A half write in the same cycle as a tick takes priority, and no decrement happens that cycle.
- R5: A tick while running with the count at zero reloads both halves to 0xFFFF and sets status bit 7. Counting then continues from 0xFFFFFFFF.
- R6: The mask register stores bits 14..0. Bit 15 always reads 0.
- R7: irq is high exactly when (mask AND status) is nonzero. It follows register updates in the next cycle.
- R8: A status write clears only the bits written as 1. Bits written as 0 are left unchanged.
- R9: A set pulse on stat_set[i] sets status bit i. If a clear of the same bit arrives in the same cycle, the set wins.
- R10: rdata is a combinational function of addr and the current register state. Unused addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle decrement enable (200 ns rate nominal) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Combinational read data |
| stat_set | input | REG_W | Per-bit status set pulses from other sources |
| irq | output | 1 | Masked interrupt request |

## Verification
The counter is driven with tick bursts in three states: while stopped (the count must not move), while running from a value spanning both halves (a borrow must cross from the low half into the high half), and while running across zero (the count must wrap to all ones, set status bit 7 and keep counting). A half write is issued in the same cycle as a tick, which separates "write wins" from "decrement then load". Status is exercised with clear words that miss, partly hit and fully hit the set bits, and with a set pulse and a clear of the same bit in one cycle. The mask is tested with all ones written, which shows both the locked bit 15 and the gating of irq.

// File: rtl/wdt_pkg.sv
// Package: register addresses and bit positions shared by the watchdog timer
// modules and its checker. Assumes a 16-bit register port.
package wdt_pkg;
    localparam int unsigned ADR_CMD    = 0;
    localparam int unsigned ADR_CNT_LO = 1;
    localparam int unsigned ADR_CNT_HI = 2;
    localparam int unsigned ADR_MASK   = 3;
    localparam int unsigned ADR_STAT   = 4;

    localparam int unsigned BIT_STOP   = 4;  // command: stop / stopped flag
    localparam int unsigned BIT_START  = 5;  // command: start / running flag
    localparam int unsigned BIT_TC     = 7;  // status: timer complete
endpackage

// File: rtl/wdt_ctrl.sv
// Module: run/stop state of the watchdog counter.
// Assumes cmd_start and cmd_stop are single-cycle decoded command bits;
// start has priority when both arrive together.
module wdt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    output logic stopped
);
    logic stopped_q;

    // Track the stopped state; reset leaves the timer stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q <= 1'b1;
        end else if (cmd_start) begin
            stopped_q <= 1'b0;
        end else if (cmd_stop) begin
            stopped_q <= 1'b1;
        end
    end

    assign stopped = stopped_q;
endmodule

// File: rtl/wdt_count.sv
// Module: down-counter built from NUM_HALVES register-width slices.
// A slice write takes priority over a tick; a tick at zero wraps to all ones
// and raises wrap for that cycle. Assumes tick is a single-cycle enable.
module wdt_count #(
    parameter int unsigned HALF_W     = 16,
    parameter int unsigned NUM_HALVES = 2,
    localparam int unsigned CNT_W     = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  stopped,
    input  logic [NUM_HALVES-1:0] half_we,
    input  logic [HALF_W-1:0]     wdata,
    output logic [CNT_W-1:0]      count,
    output logic                  wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] loaded;
    logic [CNT_W-1:0] cnt_d;

    // Per-slice load value: new data for written slices, old value for others.
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_slice
        assign loaded[g*HALF_W +: HALF_W] = half_we[g] ? wdata : cnt_q[g*HALF_W +: HALF_W];
    end

    // Next count: load, decrement, wrap or hold.
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (|half_we) begin
            cnt_d = loaded;
        end else if (tick && !stopped) begin
            if (cnt_q == '0) begin
                cnt_d = '1;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdt_irq.sv
// Module: interrupt mask and write-1-to-clear status, plus the masked
// interrupt line. The top mask bit is not stored. A set on a bit beats a
// clear of the same bit in the same cycle.
module wdt_irq #(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned TC_POS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic             stat_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] stat_set,
    input  logic             tc_set,
    output logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] status,
    output logic             irq
);
    logic [REG_W-2:0] mask_q;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] set_all;
    logic [REG_W-1:0] clr_all;

    // Combine external set pulses with the timer-complete pulse.
    always_comb begin
        set_all         = stat_set;
        set_all[TC_POS] = stat_set[TC_POS] | tc_set;
        clr_all         = stat_we ? wdata : '0;
    end

    // Mask register (bits below the top only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata[REG_W-2:0];
        end
    end

    // Status register: clear written ones, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_all) | set_all;
        end
    end

    assign mask   = {1'b0, mask_q};
    assign status = stat_q;
    assign irq    = |(mask & stat_q);
endmodule

// File: rtl/wdt_timer_top.sv
// Module: watchdog timer top. Decodes the register port, holds the run
// state, the split down-counter and the interrupt logic, and returns
// combinational read data. Assumes writes and ticks are synchronous to clk.
module wdt_timer_top #(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  stat_set,
    output logic              irq
);
    import wdt_pkg::*;

    localparam int unsigned HALVES = 2;
    localparam int unsigned CNT_W  = REG_W * HALVES;

    logic              we_cmd, we_mask, we_stat;
    logic [HALVES-1:0] we_half;
    logic              stopped_q;
    logic [CNT_W-1:0]  cnt_val;
    logic              wrap_p;
    logic [REG_W-1:0]  mask_val;
    logic [REG_W-1:0]  stat_val;

    // Write decode.
    always_comb begin
        we_cmd     = wr_en && (addr == ADDR_W'(ADR_CMD));
        we_half[0] = wr_en && (addr == ADDR_W'(ADR_CNT_LO));
        we_half[1] = wr_en && (addr == ADDR_W'(ADR_CNT_HI));
        we_mask    = wr_en && (addr == ADDR_W'(ADR_MASK));
        we_stat    = wr_en && (addr == ADDR_W'(ADR_STAT));
    end

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (we_cmd && wdata[BIT_START]),
        .cmd_stop  (we_cmd && wdata[BIT_STOP]),
        .stopped   (stopped_q)
    );

    wdt_count #(.HALF_W(REG_W), .NUM_HALVES(HALVES)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .stopped (stopped_q),
        .half_we (we_half),
        .wdata   (wdata),
        .count   (cnt_val),
        .wrap    (wrap_p)
    );

    wdt_irq #(.REG_W(REG_W), .TC_POS(BIT_TC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (we_mask),
        .stat_we  (we_stat),
        .wdata    (wdata),
        .stat_set (stat_set),
        .tc_set   (wrap_p),
        .mask     (mask_val),
        .status   (stat_val),
        .irq      (irq)
    );

    // Combinational read mux with the live count.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADR_CMD): begin
                rdata[BIT_STOP]  = stopped_q;
                rdata[BIT_START] = ~stopped_q;
            end
            ADDR_W'(ADR_CNT_LO): rdata = cnt_val[REG_W-1:0];
            ADDR_W'(ADR_CNT_HI): rdata = cnt_val[CNT_W-1:REG_W];
            ADDR_W'(ADR_MASK):   rdata = mask_val;
            ADDR_W'(ADR_STAT):   rdata = stat_val;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_check.sv
// Checker: temporal properties of the watchdog timer, bound to the top.
module wdt_check #(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned CNT_W = 2 * REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  stat_set,
    input logic [CNT_W-1:0]  count,
    input logic              stopped,
    input logic [REG_W-1:0]  status
);
    import wdt_pkg::*;

    logic cnt_wr, stat_wr;
    logic [REG_W-1:0] tc_mask;
    assign cnt_wr  = wr_en && (addr == ADDR_W'(ADR_CNT_LO) || addr == ADDR_W'(ADR_CNT_HI));
    assign stat_wr = wr_en && (addr == ADDR_W'(ADR_STAT));
    assign tc_mask = REG_W'(1) << BIT_TC;

    a_r3_stopped_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !cnt_wr) |=> $stable(count));

    a_r2_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && tick_en && !cnt_wr && count != '0) |=> (count == $past(count) - 1'b1));

    a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && tick_en && !cnt_wr && count == '0) |=> (count == '1 && status[BIT_TC]));

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status & $past(wdata & ~stat_set & ~tc_mask)) == '0));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set != '0) |=> ((status & $past(stat_set)) == $past(stat_set)));
endmodule

bind wdt_timer_top wdt_check #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .stat_set (stat_set),
    .count    (cnt_val),
    .stopped  (stopped_q),
    .status   (stat_val)
);

// File: tb/sim_wdt_timer_top.sv
// Directed bench for the watchdog timer: one task per scenario.
module sim_wdt_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] stat_set = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wdt_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .stat_set(stat_set), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rd_check("R1 cmd", 3'd0, 16'h0010);
        rd_check("R1 lo", 3'd1, 16'h0000);
        rd_check("R1 hi", 3'd2, 16'h0000);
        rd_check("R1 mask", 3'd3, 16'h0000);
        rd_check("R1 status", 3'd4, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_stopped_load;
        wr(3'd2, 16'h0001);
        wr(3'd1, 16'h0003);
        ticks(5);
        rd_check("R3 stopped ignores tick lo", 3'd1, 16'h0003);
        rd_check("R4 hi half loaded", 3'd2, 16'h0001);
    endtask

    task automatic t_run_borrow;
        wr(3'd0, 16'h0020);
        rd_check("R2 cmd running", 3'd0, 16'h0020);
        ticks(5);
        rd_check("R2 borrow lo", 3'd1, 16'hFFFE);
        rd_check("R2 borrow hi", 3'd2, 16'h0000);
    endtask

    task automatic t_stop;
        wr(3'd0, 16'h0010);
        rd_check("R3 cmd stopped", 3'd0, 16'h0010);
        ticks(3);
        rd_check("R3 frozen lo", 3'd1, 16'hFFFE);
        wr(3'd0, 16'h0030);
        rd_check("R3 both bits run", 3'd0, 16'h0020);
    endtask

    task automatic t_wrap;
        wr(3'd1, 16'h0002);
        ticks(3);
        rd_check("R5 reload lo", 3'd1, 16'hFFFF);
        rd_check("R5 reload hi", 3'd2, 16'hFFFF);
        rd_check("R5 tc bit", 3'd4, 16'h0080);
        ticks(2);
        rd_check("R5 continues", 3'd1, 16'hFFFD);
        check("R7 irq masked off", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_mask_irq;
        wr(3'd3, 16'hFFFF);
        rd_check("R6 bit15 locked", 3'd3, 16'h7FFF);
        check("R7 irq on", {15'd0, irq}, 16'h0001);
    endtask

    task automatic t_w1c;
        wr(3'd4, 16'h0000);
        rd_check("R8 zero write", 3'd4, 16'h0080);
        wr(3'd4, 16'h0001);
        rd_check("R8 miss write", 3'd4, 16'h0080);
        wr(3'd4, 16'h0080);
        rd_check("R8 clear", 3'd4, 16'h0000);
        check("R7 irq off", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_set;
        @(negedge clk); stat_set = 16'h8000;
        @(negedge clk); stat_set = 16'h0000;
        rd_check("R9 set bit15", 3'd4, 16'h8000);
        check("R7 bit15 unmaskable off", {15'd0, irq}, 16'h0000);
        @(negedge clk); stat_set = 16'h0004;
        @(negedge clk); stat_set = 16'h0000;
        check("R7 irq from set", {15'd0, irq}, 16'h0001);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 16'h0004; stat_set = 16'h0004;
        @(negedge clk);
        wr_en = 1'b0; stat_set = 16'h0000;
        rd_check("R9 set beats clear", 3'd4, 16'h8004);
        wr(3'd4, 16'h8004);
        rd_check("R8 clear both", 3'd4, 16'h0000);
    endtask

    task automatic t_write_vs_tick;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wdata = 16'h0000; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        rd_check("R4 write wins lo", 3'd1, 16'hFFFD);
        rd_check("R4 write wins hi", 3'd2, 16'h0000);
    endtask

    task automatic t_unused;
        wr(3'd6, 16'hFFFF);
        rd_check("R10 unused reads 0", 3'd6, 16'h0000);
        rd_check("R10 mask untouched", 3'd3, 16'h7FFF);
        rd_check("R10 live lo", 3'd1, 16'hFFFD);
        ticks(1);
        rd_check("R10 live after tick", 3'd1, 16'hFFFC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped_load();
        t_run_borrow();
        t_stop();
        t_wrap();
        t_mask_irq();
        t_w1c();
        t_set();
        t_write_vs_tick();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule